// File: doc/BRIEF.md
# Permanent Fault Supervisor

This block watches a set of safety conditions and turns a persistent one into a permanent, irreversible fault. Each condition arrives as an over-threshold flag from measurement logic outside the block. The flags are looked at only on a once-per-second tick, and only while the device is in its normal or sleep mode. A condition that is enabled and over threshold at a tick raises an alert straight away. If the condition is still over threshold on enough consecutive ticks, set by a programmable delay, the block declares a permanent fault. A host command can also declare the fault directly.

Once the fault is declared, the block latches it until reset and stops monitoring. It holds both power switches off. It then runs an ordered shutdown sequence: first an optional fuse blow, then an optional record written to one-time memory, and only after both have finished, an optional request for deep sleep. A configuration bit chooses whether the two auxiliary regulator enables are forced off at the moment the fault latches. The host can still write those enables later.

Top module: `pf_supervisor`

## Requirements
- R1: Conditions are sampled only in a cycle where `tick_i` is 1 and `mode_i` is 0 (normal) or 1 (sleep). Ticks in modes 2 and 3 have no effect, and changes of `over_i` between ticks have no effect.
- R2: When a tick sample finds `over_i[i] & enable_i[i]` set, `alert_vec_o[i]` is 1 from the next cycle. `alert_o` is the OR of all bits of `alert_vec_o`.
- R3: An alert bit clears only when a tick sample finds its condition low. A condition whose enable bit is 0 counts as low.
- R4: A condition trips the fault on its (`delay_i`+1)-th consecutive high tick sample. Any low sample restarts the count. The count saturates at its maximum, so the maximum delay still trips.
- R5: `fault_src_o[i]` (for i below N_COND) is set for each condition that trips. Bit N_COND is set by `cmd_fault_i`, which works in any mode and in any cycle. `fault_o` is the OR of these bits, becomes visible one cycle after the cause, and every bit stays set until reset.
- R6: From the cycle after the fault latches, `fet_off_o` is 1. Later tick samples no longer change `alert_vec_o` or the condition bits of `fault_src_o`.
- R7: With `cfg_fuse_en_i` set, `fuse_blow_o` is 1 from the cycle after the fault latches. It stays 1 through the cycle in which `fuse_done_i` is seen.
- R8: With `cfg_otp_en_i` set, `otp_prog_o` is 1 after the fuse step ends, or right after the latch when the fuse step is disabled. It stays 1 through the cycle in which `otp_done_i` is seen. `fuse_blow_o` and `otp_prog_o` are never 1 together.
- R9: `deep_sleep_o` is 1 only after both enabled steps have finished, and only while `cfg_sleep_en_i` is 1.
- R10: `reg_en_o` resets to 0, and a `reg_wr_i` pulse loads `reg_wdata_i` on the next cycle. When the fault latches with `cfg_reg_off_i` set, both enables go to 0, even against a write in the same cycle. With `cfg_reg_off_i` clear they keep their value. Writes made after the fault still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second evaluation tick, one cycle wide |
| mode_i | input | 2 | Power mode: 0 normal, 1 sleep, 2/3 other |
| over_i | input | N_COND | Per-condition over-threshold flags |
| enable_i | input | N_COND | Per-condition check enables |
| delay_i | input | DLY_W | Persistence delay in ticks |
| cfg_fuse_en_i | input | 1 | Blow fuse on fault |
| cfg_otp_en_i | input | 1 | Write one-time record on fault |
| cfg_reg_off_i | input | 1 | Force regulator enables off on fault |
| cfg_sleep_en_i | input | 1 | Request deep sleep after shutdown |
| cmd_fault_i | input | 1 | Host command: declare fault |
| reg_wr_i | input | 1 | Host write strobe for regulator enables |
| reg_wdata_i | input | 2 | Regulator enable write data |
| fuse_done_i | input | 1 | Fuse blow finished |
| otp_done_i | input | 1 | One-time memory write finished |
| alert_o | output | 1 | Any condition alert |
| alert_vec_o | output | N_COND | Per-condition alerts |
| fault_o | output | 1 | Permanent fault latched |
| fault_src_o | output | N_COND+1 | Fault sources, top bit is the command |
| fet_off_o | output | 1 | Hold both power switches off |
| fuse_blow_o | output | 1 | Fuse blow request |
| otp_prog_o | output | 1 | One-time memory write request |
| reg_en_o | output | 2 | Auxiliary regulator enables |
| deep_sleep_o | output | 1 | Deep-sleep request |

## Verification
Every registered result is due on the clock edge that follows its cause. Alerts, fault sources, `fault_o`, `fet_off_o`, the first sequencer output and the regulator enables change one cycle after a tick, a command or a write. Each step of the sequence advances one cycle after its done input is seen. `deep_sleep_o` follows the final state at once, with the current value of the sleep enable.

The bench drives its inputs 1 ns after each rising edge. It advances a behavioural model on the rising edge and compares every output against that model at the falling edge, so each comparison sees exactly one edge's worth of change. Directed checks after each scenario pin down the fault sources and regulator values.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    SEQ_MON  = 2'd0,
    SEQ_FUSE = 2'd1,
    SEQ_OTP  = 2'd2,
    SEQ_DONE = 2'd3
  } seq_state_t;

  localparam logic [1:0] MODE_NORMAL = 2'd0;
  localparam logic [1:0] MODE_SLEEP  = 2'd1;
endpackage

// File: rtl/pfs_cond_chan.sv
module pfs_cond_chan #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             hit_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             alert_o,
  output logic             trip_o
);
  localparam logic [DLY_W-1:0] CNT_MAX = '1;

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             alert_q, alert_d;

  // Persistence count holds consecutive high samples seen before this one.
  always_comb begin
    cnt_d   = cnt_q;
    alert_d = alert_q;
    if (eval_i) begin
      alert_d = hit_i;
      if (!hit_i) begin
        cnt_d = '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign trip_o  = eval_i && hit_i && (cnt_q >= delay_i);
  assign alert_o = alert_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alert_q <= 1'b0;
    end else if (eval_i) begin
      cnt_q   <= cnt_d;
      alert_q <= alert_d;
    end
  end
endmodule

// File: rtl/pfs_shutdown_seq.sv
module pfs_shutdown_seq
  import pfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fuse_en_i,
  input  logic otp_en_i,
  input  logic sleep_en_i,
  input  logic fuse_done_i,
  input  logic otp_done_i,
  output logic fet_off_o,
  output logic fuse_blow_o,
  output logic otp_prog_o,
  output logic deep_sleep_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_MON: begin
        if (start_i) begin
          if (fuse_en_i)     state_d = SEQ_FUSE;
          else if (otp_en_i) state_d = SEQ_OTP;
          else               state_d = SEQ_DONE;
        end
      end
      SEQ_FUSE: begin
        if (fuse_done_i) state_d = otp_en_i ? SEQ_OTP : SEQ_DONE;
      end
      SEQ_OTP: begin
        if (otp_done_i) state_d = SEQ_DONE;
      end
      SEQ_DONE: state_d = SEQ_DONE;
      default:  state_d = SEQ_MON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_MON;
    else        state_q <= state_d;
  end

  assign fet_off_o    = (state_q != SEQ_MON);
  assign fuse_blow_o  = (state_q == SEQ_FUSE);
  assign otp_prog_o   = (state_q == SEQ_OTP);
  assign deep_sleep_o = (state_q == SEQ_DONE) && sleep_en_i;
endmodule

// File: rtl/pfs_reg_ctl.sv
module pfs_reg_ctl #(
  parameter int REG_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_off_i,
  input  logic             wr_i,
  input  logic [REG_N-1:0] wdata_i,
  output logic [REG_N-1:0] en_o
);
  logic [REG_N-1:0] en_q, en_d;
  logic             upd;

  // A fault with the force-off option set wins over a write in the same cycle.
  always_comb begin
    upd  = force_off_i || wr_i;
    en_d = force_off_i ? '0 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   en_q <= '0;
    else if (upd) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/pf_supervisor.sv
module pf_supervisor
  import pfs_pkg::*;
#(
  parameter int N_COND = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic [N_COND-1:0] over_i,
  input  logic [N_COND-1:0] enable_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              cfg_fuse_en_i,
  input  logic              cfg_otp_en_i,
  input  logic              cfg_reg_off_i,
  input  logic              cfg_sleep_en_i,
  input  logic              cmd_fault_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_wdata_i,
  input  logic              fuse_done_i,
  input  logic              otp_done_i,
  output logic              alert_o,
  output logic [N_COND-1:0] alert_vec_o,
  output logic              fault_o,
  output logic [N_COND:0]   fault_src_o,
  output logic              fet_off_o,
  output logic              fuse_blow_o,
  output logic              otp_prog_o,
  output logic [1:0]        reg_en_o,
  output logic              deep_sleep_o
);
  localparam int SRC_W = N_COND + 1;

  logic              mode_ok;
  logic              eval;
  logic [N_COND-1:0] hit;
  logic [N_COND-1:0] trip;
  logic              start;
  logic [SRC_W-1:0]  src_q, src_d;

  assign mode_ok = (mode_i == MODE_NORMAL) || (mode_i == MODE_SLEEP);
  assign eval    = tick_i && mode_ok && !fault_o;
  assign hit     = over_i & enable_i;

  for (genvar g = 0; g < N_COND; g++) begin : g_chan
    pfs_cond_chan #(.DLY_W(DLY_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .eval_i  (eval),
      .hit_i   (hit[g]),
      .delay_i (delay_i),
      .alert_o (alert_vec_o[g]),
      .trip_o  (trip[g])
    );
  end

  assign start = !fault_o && ((|trip) || cmd_fault_i);

  always_comb begin
    src_d = src_q | {cmd_fault_i, trip};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign fault_src_o = src_q;
  assign fault_o     = |src_q;
  assign alert_o     = |alert_vec_o;

  pfs_shutdown_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .fuse_en_i    (cfg_fuse_en_i),
    .otp_en_i     (cfg_otp_en_i),
    .sleep_en_i   (cfg_sleep_en_i),
    .fuse_done_i  (fuse_done_i),
    .otp_done_i   (otp_done_i),
    .fet_off_o    (fet_off_o),
    .fuse_blow_o  (fuse_blow_o),
    .otp_prog_o   (otp_prog_o),
    .deep_sleep_o (deep_sleep_o)
  );

  pfs_reg_ctl #(.REG_N(2)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_off_i (start && cfg_reg_off_i),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .en_o        (reg_en_o)
  );
endmodule

// File: rtl/pf_supervisor_chk.sv
module pf_supervisor_chk #(
  parameter int N_COND = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              cfg_reg_off_i,
  input logic [N_COND-1:0] alert_vec_o,
  input logic              fault_o,
  input logic [N_COND:0]   fault_src_o,
  input logic              fet_off_o,
  input logic              fuse_blow_o,
  input logic              otp_prog_o,
  input logic [1:0]        reg_en_o,
  input logic              deep_sleep_o
);
  // R2
  alert_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(alert_vec_o));
  // R5
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);
  // R6
  fet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> fet_off_o);
  // R6
  frozen_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> $stable(fault_src_o[N_COND-1:0]));
  // R8
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fuse_blow_o && otp_prog_o));
  // R9
  sleep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep_o |-> (fet_off_o && !fuse_blow_o && !otp_prog_o));
  // R10
  reg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_o) && $past(cfg_reg_off_i)) |-> (reg_en_o == 2'b00));
endmodule

bind pf_supervisor pf_supervisor_chk #(.N_COND(N_COND)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .cfg_reg_off_i (cfg_reg_off_i),
  .alert_vec_o   (alert_vec_o),
  .fault_o       (fault_o),
  .fault_src_o   (fault_src_o),
  .fet_off_o     (fet_off_o),
  .fuse_blow_o   (fuse_blow_o),
  .otp_prog_o    (otp_prog_o),
  .reg_en_o      (reg_en_o),
  .deep_sleep_o  (deep_sleep_o)
);

// File: tb/pf_supervisor_tb.sv
`timescale 1ns/1ps
module pf_supervisor_tb;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int CMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, cmd_fault_i = 0, reg_wr_i = 0, fuse_done_i = 0, otp_done_i = 0;
  logic cfg_fuse_en_i = 0, cfg_otp_en_i = 0, cfg_reg_off_i = 0, cfg_sleep_en_i = 0;
  logic [1:0] mode_i = 0, reg_wdata_i = 0;
  logic [N-1:0] over_i = 0, enable_i = 0;
  logic [DW-1:0] delay_i = 0;
  logic alert_o, fault_o, fet_off_o, fuse_blow_o, otp_prog_o, deep_sleep_o;
  logic [N-1:0] alert_vec_o;
  logic [N:0] fault_src_o;
  logic [1:0] reg_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pf_supervisor #(.N_COND(N), .DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i), .over_i(over_i),
    .enable_i(enable_i), .delay_i(delay_i), .cfg_fuse_en_i(cfg_fuse_en_i),
    .cfg_otp_en_i(cfg_otp_en_i), .cfg_reg_off_i(cfg_reg_off_i),
    .cfg_sleep_en_i(cfg_sleep_en_i), .cmd_fault_i(cmd_fault_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .fuse_done_i(fuse_done_i), .otp_done_i(otp_done_i),
    .alert_o(alert_o), .alert_vec_o(alert_vec_o), .fault_o(fault_o),
    .fault_src_o(fault_src_o), .fet_off_o(fet_off_o), .fuse_blow_o(fuse_blow_o),
    .otp_prog_o(otp_prog_o), .reg_en_o(reg_en_o), .deep_sleep_o(deep_sleep_o)
  );

  // Behavioural reference
  logic [N-1:0] m_alert;
  int m_cnt[N];
  logic [N:0] m_src;
  int m_st;            // 0 monitoring, 1 fuse, 2 record, 3 finished
  logic [1:0] m_reg;
  bit m_ev, m_h, m_start;
  logic [N-1:0] m_tr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_alert = '0; m_src = '0; m_st = 0; m_reg = 2'b00;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      m_ev = tick_i && (mode_i <= 2'd1) && (m_src == '0);
      m_tr = '0;
      for (int i = 0; i < N; i++) begin
        if (m_ev) begin
          m_h = over_i[i] && enable_i[i];
          if (m_h && m_cnt[i] >= int'(delay_i)) m_tr[i] = 1'b1;
          m_alert[i] = m_h;
          m_cnt[i] = m_h ? ((m_cnt[i] < CMAX) ? m_cnt[i] + 1 : CMAX) : 0;
        end
      end
      m_start = (m_src == '0) && ((m_tr != '0) || cmd_fault_i);
      case (m_st)
        0: if (m_start) m_st = cfg_fuse_en_i ? 1 : (cfg_otp_en_i ? 2 : 3);
        1: if (fuse_done_i) m_st = cfg_otp_en_i ? 2 : 3;
        2: if (otp_done_i) m_st = 3;
        default: m_st = 3;
      endcase
      if (m_start && cfg_reg_off_i) m_reg = 2'b00;
      else if (reg_wr_i) m_reg = reg_wdata_i;
      m_src = m_src | {cmd_fault_i, m_tr};
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(alert_vec_o == m_alert, "R2", "alert_vec_o", int'(alert_vec_o), int'(m_alert));
      chk(alert_o == (|m_alert), "R3", "alert_o", int'(alert_o), int'(|m_alert));
      chk(fault_src_o == m_src, "R5", "fault_src_o", int'(fault_src_o), int'(m_src));
      chk(fault_o == (|m_src), "R4", "fault_o", int'(fault_o), int'(|m_src));
      chk(fet_off_o == (m_st != 0), "R6", "fet_off_o", int'(fet_off_o), int'(m_st != 0));
      chk(fuse_blow_o == (m_st == 1), "R7", "fuse_blow_o", int'(fuse_blow_o), int'(m_st == 1));
      chk(otp_prog_o == (m_st == 2), "R8", "otp_prog_o", int'(otp_prog_o), int'(m_st == 2));
      chk(deep_sleep_o == ((m_st == 3) && cfg_sleep_en_i), "R9", "deep_sleep_o",
          int'(deep_sleep_o), int'((m_st == 3) && cfg_sleep_en_i));
      chk(reg_en_o == m_reg, "R10", "reg_en_o", int'(reg_en_o), int'(m_reg));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic tick1();
    tick_i = 1; step(1); tick_i = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick_i = 0; cmd_fault_i = 0; reg_wr_i = 0; fuse_done_i = 0; otp_done_i = 0;
    over_i = '0; enable_i = '0; mode_i = 2'd0;
    #7; rst_n = 1; step(1);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Scenario A: reset state (R10 reset value), alert set/clear, persistence, full sequence
    do_reset();
    chk(reg_en_o == 2'b00 && fault_o == 1'b0 && alert_o == 1'b0, "R10", "reset state",
        int'({reg_en_o, fault_o, alert_o}), 0);
    cfg_fuse_en_i = 1; cfg_otp_en_i = 1; cfg_reg_off_i = 1; cfg_sleep_en_i = 1;
    delay_i = 8'd2; enable_i = 4'b0001;
    reg_wr_i = 1; reg_wdata_i = 2'b11; step(1); reg_wr_i = 0;
    over_i = 4'b0001; tick1();
    chk(alert_vec_o == 4'b0001, "R2", "alert after first over tick", int'(alert_vec_o), 1);
    over_i = 4'b0000; step(3); over_i = 4'b0001; step(2);   // dip between ticks ignored (R1)
    chk(alert_o == 1'b1, "R1", "alert held across dip", int'(alert_o), 1);
    over_i = 4'b0000; tick1();
    chk(alert_o == 1'b0, "R3", "alert cleared on low tick", int'(alert_o), 0);
    over_i = 4'b0001;
    tick1(); step(2); tick1(); step(2);
    chk(fault_o == 1'b0, "R4", "no fault before delay", int'(fault_o), 0);
    tick1();
    chk(fault_src_o == 5'b00001, "R4", "fault on third tick", int'(fault_src_o), 1);
    chk(reg_en_o == 2'b00, "R10", "regs forced off", int'(reg_en_o), 0);
    over_i = 4'b0000; enable_i = 4'b1111; over_i = 4'b0110; tick1(); tick1();
    chk(alert_vec_o == 4'b0001, "R6", "monitoring frozen", int'(alert_vec_o), 1);
    step(3); fuse_done_i = 1; step(1); fuse_done_i = 0;
    chk(otp_prog_o == 1'b1 && deep_sleep_o == 1'b0, "R8", "record after fuse",
        int'({otp_prog_o, deep_sleep_o}), 2);
    step(2); otp_done_i = 1; step(1); otp_done_i = 0;
    chk(deep_sleep_o == 1'b1, "R9", "deep sleep after both steps", int'(deep_sleep_o), 1);
    reg_wr_i = 1; reg_wdata_i = 2'b01; step(1); reg_wr_i = 0;
    chk(reg_en_o == 2'b01, "R10", "write after fault", int'(reg_en_o), 1);
    cfg_sleep_en_i = 0; step(1);

    // Scenario B: other modes ignored, disabled input ignored, command fault
    do_reset();
    cfg_fuse_en_i = 0; cfg_otp_en_i = 0; cfg_reg_off_i = 0; cfg_sleep_en_i = 1;
    delay_i = 8'd0; enable_i = 4'b0100; over_i = 4'b1100;
    reg_wr_i = 1; reg_wdata_i = 2'b10; step(1); reg_wr_i = 0;
    mode_i = 2'd2; tick1(); mode_i = 2'd3; tick1();
    chk(alert_o == 1'b0 && fault_o == 1'b0, "R1", "ticks ignored in other modes",
        int'({alert_o, fault_o}), 0);
    mode_i = 2'd2; cmd_fault_i = 1; step(1); cmd_fault_i = 0;
    chk(fault_src_o == 5'b10000, "R5", "command fault", int'(fault_src_o), 16);
    chk(reg_en_o == 2'b10, "R10", "regs kept", int'(reg_en_o), 2);
    step(2);

    // Scenario C: zero delay in sleep mode, disabled bit not tripping, sleep request off
    do_reset();
    cfg_sleep_en_i = 0; cfg_otp_en_i = 1; mode_i = 2'd1;
    delay_i = 8'd0; enable_i = 4'b0010; over_i = 4'b1010;
    tick1();
    chk(fault_src_o == 5'b00010, "R4", "zero delay trip", int'(fault_src_o), 2);
    chk(otp_prog_o == 1'b1, "R8", "record without fuse", int'(otp_prog_o), 1);
    otp_done_i = 1; step(1); otp_done_i = 0; step(1);
    chk(deep_sleep_o == 1'b0, "R9", "no sleep when disabled", int'(deep_sleep_o), 0);

    // Scenario D: maximum delay with saturating count
    do_reset();
    cfg_otp_en_i = 0; mode_i = 2'd0; delay_i = 8'hFF; enable_i = 4'b1000; over_i = 4'b1000;
    tick_i = 1; step(CMAX); tick_i = 0; step(1);
    chk(fault_o == 1'b0, "R4", "no trip before max delay", int'(fault_o), 0);
    tick_i = 1; step(1); tick_i = 0;
    chk(fault_src_o == 5'b01000, "R4", "trip at max delay", int'(fault_src_o), 8);
    step(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule